// File: doc/BRIEF.md
# Byte-Wide Bus Cycle Sequencer

This block turns internal transfer requests into external bus cycles on an 8-bit multiplexed address/data bus. A requester presents a read or a write of one byte or one 16-bit word, in memory or I/O space. A halt request is also accepted. The sequencer runs each byte transfer as a four-state cycle (T1 to T4) and inserts wait states while the ready input is low. A 16-bit transfer is split into two back-to-back byte cycles. The block pulses `done` once the whole transfer has finished. For reads it also returns the assembled 16-bit value.

The low address byte and the data share one set of lines. Address strobe `ale` marks the address phase, and an external latch captures the low address byte while `ale` is high. The upper address bits come out on their own output-only lines. They are loaded at the start of each byte cycle and held after that. No byte-lane enable exists, because every transfer is one byte wide. The three outputs `io_m`, `dt_r` and `sso` together encode the type of cycle that is running. When a halt is entered, its status is driven one clock before the `ale` pulse, so that the status and the address strobe can be captured together.

Top module: `bus8_cycle_ctrl`

## Requirements
- R1: After synchronous reset the outputs take these values: `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `done`=0, `req_ready`=1. The status outputs show the passive code `io_m`=0, `dt_r`=1, `sso`=1.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while idle. Taking the accept edge as cycle 0, a byte transfer has T1 in cycle 1 with `ale` high for that one cycle. The strobe (`rd_n` for a read, `wr_n` for a write) is low in cycles 2 and 3. `done` is high for exactly cycle 5.
- R3: `ready` is sampled at the end of T3 and at the end of each wait state. Every low sample adds one wait cycle, and the strobe stays low during that cycle. Each wait cycle delays `done` by one cycle.
- R4: A 16-bit transfer (`req_wide`=1) runs two byte cycles. The low byte uses address A and goes first. The high byte uses A+1, modulo 2^ADDR_W. `done` comes 4 cycles later than for a byte transfer, plus any wait cycles.
- R5: `a_hi` carries address bits [ADDR_W-1:8] of the current byte cycle from T1 onward. It does not change while a strobe is low.
- R6: In T1 `ad_out` carries address bits [7:0] and `ad_oe`=1. During a write, `ad_out` carries the data byte from T2 through T4 with `ad_oe`=1. During a read, `ad_oe`=0 from T2 through T4.
- R7: From T1 through T4, `io_m`=1 for I/O space and 0 for memory, `dt_r`=0 for a read and 1 for a write, and `sso` is the inverse of `dt_r`.
- R8: A read byte is taken from `ad_in` at the edge that ends the last T3 or wait state. `rdata[7:0]` holds the first byte. `rdata[15:8]` holds the second byte, or 0 for a byte read. `rdata` is valid while `done` is 1.
- R9: A halt request takes priority over `req_write`. In the cycle after acceptance the status is `io_m`=1, `dt_r`=1, `sso`=1 with `ale` low. `ale` is high in the cycle after that. From then on the block stays halted with `ale`=0 and `req_ready`=0, and it ignores every request until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_halt | input | 1 | Request to enter halt |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | 2*BUS_W | Write data, low byte first |
| req_ready | output | 1 | Idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 2*BUS_W | Assembled read data |
| ready | input | 1 | Slave ready; low inserts wait states |
| ad_in | input | BUS_W | Data returned on the shared lines |
| ad_out | output | BUS_W | Address low byte / write data |
| ad_oe | output | 1 | Drive enable for the shared lines |
| a_hi | output | ADDR_W-BUS_W | Held upper address lines |
| ale | output | 1 | Address strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dt_r | output | 1 | Direction: 1 write, 0 read |
| io_m | output | 1 | Space: 1 I/O, 0 memory |
| sso | output | 1 | Status bit completing the cycle-type code |

## Verification
The bench builds the sequencer with its default sizes: a 16-bit address and an 8-bit bus, which gives eight upper address lines and a 16-bit word. These sizes let a 16-bit transfer start at address 0xFFFF, so the bench can check that the second byte wraps to 0x0000. With 0 to 3 wait states per byte cycle, the bench can check the strobe lengths and `done` latencies that follow from each combination of width and direction.

// File: rtl/bus8_pkg.sv
package bus8_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4,
    ST_HPRE,
    ST_HALE,
    ST_HALTED
  } bus_state_e;

  // strobe window: T2, T3 and wait states
  function automatic logic is_strobe(bus_state_e s);
    return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
  endfunction

  // whole byte cycle, T1 through T4
  function automatic logic is_cycle(bus_state_e s);
    return (s == ST_T1) || is_strobe(s) || (s == ST_T4);
  endfunction

  function automatic logic is_halt(bus_state_e s);
    return (s == ST_HPRE) || (s == ST_HALE) || (s == ST_HALTED);
  endfunction

endpackage

// File: rtl/bus8_seq.sv
module bus8_seq
  import bus8_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_wide,
  input  logic                 req_io,
  input  logic                 req_halt,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [2*BUS_W-1:0]   req_wdata,
  input  logic                 ready,
  output bus_state_e           st_q,
  output bus_state_e           st_d,
  output logic                 beat_q,
  output logic                 beat_d,
  output logic                 write_q,
  output logic                 write_d,
  output logic                 io_d,
  output logic [ADDR_W-1:0]    addr_d,
  output logic [2*BUS_W-1:0]   wdata_d,
  output logic                 req_ready,
  output logic                 done
);
  localparam int WORD_W = 2 * BUS_W;

  logic              accept;
  logic              wide_q;
  logic              io_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;

  assign accept  = (st_q == ST_IDLE) && req_valid;
  assign write_d = accept ? req_write : write_q;
  assign io_d    = accept ? req_io    : io_q;
  assign addr_d  = accept ? req_addr  : addr_q;
  assign wdata_d = accept ? req_wdata : wdata_q;

  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_halt) begin
            st_d = ST_HPRE;
          end else begin
            st_d   = ST_T1;
            beat_d = 1'b0;
          end
        end
      end
      ST_T1:        st_d = ST_T2;
      ST_T2:        st_d = ST_T3;
      ST_T3, ST_TW: st_d = ready ? ST_T4 : ST_TW;
      ST_T4: begin
        if (wide_q && !beat_q) begin
          st_d   = ST_T1;
          beat_d = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_HPRE:      st_d = ST_HALE;
      ST_HALE:      st_d = ST_HALTED;
      ST_HALTED:    st_d = ST_HALTED;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      beat_q    <= 1'b0;
      write_q   <= 1'b0;
      wide_q    <= 1'b0;
      io_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      req_ready <= 1'b1;
      done      <= 1'b0;
    end else begin
      st_q      <= st_d;
      beat_q    <= beat_d;
      req_ready <= (st_d == ST_IDLE);
      done      <= (st_q == ST_T4) && (st_d == ST_IDLE);
      if (accept) begin
        write_q <= req_write;
        wide_q  <= req_wide;
        io_q    <= req_io;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

endmodule

// File: rtl/bus8_strobe.sv
module bus8_strobe
  import bus8_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bus_state_e st_d,
  input  logic       write_d,
  input  logic       io_d,
  output logic       ale,
  output logic       rd_n,
  output logic       wr_n,
  output logic       io_m,
  output logic       dt_r,
  output logic       sso
);
  // outputs follow the next state, so each is a plain flop
  always_ff @(posedge clk) begin
    if (rst) begin
      ale  <= 1'b0;
      rd_n <= 1'b1;
      wr_n <= 1'b1;
      io_m <= 1'b0;
      dt_r <= 1'b1;
      sso  <= 1'b1;
    end else begin
      ale  <= (st_d == ST_T1) || (st_d == ST_HALE);
      rd_n <= !(is_strobe(st_d) && !write_d);
      wr_n <= !(is_strobe(st_d) && write_d);
      if (is_cycle(st_d)) begin
        io_m <= io_d;
        dt_r <= write_d;
        sso  <= !write_d;
      end else if (is_halt(st_d)) begin
        io_m <= 1'b1;
        dt_r <= 1'b1;
        sso  <= 1'b1;
      end else begin
        io_m <= 1'b0;
        dt_r <= 1'b1;
        sso  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/bus8_addr_path.sv
module bus8_addr_path
  import bus8_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  bus_state_e               st_d,
  input  logic                     beat_d,
  input  logic                     write_d,
  input  logic [ADDR_W-1:0]        addr_d,
  input  logic [2*BUS_W-1:0]       wdata_d,
  output logic [ADDR_W-BUS_W-1:0]  a_hi,
  output logic [BUS_W-1:0]         ad_out,
  output logic                     ad_oe
);
  logic [ADDR_W-1:0] byte_addr;
  logic [BUS_W-1:0]  wbyte;

  assign byte_addr = addr_d + {{(ADDR_W-1){1'b0}}, beat_d};
  assign wbyte     = beat_d ? wdata_d[2*BUS_W-1:BUS_W] : wdata_d[BUS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      a_hi   <= '0;
      ad_out <= '0;
      ad_oe  <= 1'b0;
    end else if (st_d == ST_T1) begin
      a_hi   <= byte_addr[ADDR_W-1:BUS_W];
      ad_out <= byte_addr[BUS_W-1:0];
      ad_oe  <= 1'b1;
    end else if (write_d && (is_strobe(st_d) || (st_d == ST_T4))) begin
      ad_out <= wbyte;
      ad_oe  <= 1'b1;
    end else begin
      ad_oe  <= 1'b0;
    end
  end

endmodule

// File: rtl/bus8_rdata_asm.sv
module bus8_rdata_asm
  import bus8_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  bus_state_e           st_q,
  input  logic                 beat_q,
  input  logic                 write_q,
  input  logic                 ready,
  input  logic [BUS_W-1:0]     ad_in,
  output logic [2*BUS_W-1:0]   rdata
);
  localparam int LANES = 2;

  logic clear;
  logic cap;

  assign clear = (st_q == ST_T1) && !beat_q;
  assign cap   = ((st_q == ST_T3) || (st_q == ST_TW)) && ready && !write_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BUS_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        lane_q <= '0;
      end else if (cap && (int'(beat_q) == g)) begin
        lane_q <= ad_in;
      end
    end
    assign rdata[g*BUS_W +: BUS_W] = lane_q;
  end

endmodule

// File: rtl/bus8_cycle_ctrl.sv
module bus8_cycle_ctrl
  import bus8_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_wide,
  input  logic                     req_io,
  input  logic                     req_halt,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [2*BUS_W-1:0]       req_wdata,
  output logic                     req_ready,
  output logic                     done,
  output logic [2*BUS_W-1:0]       rdata,
  input  logic                     ready,
  input  logic [BUS_W-1:0]         ad_in,
  output logic [BUS_W-1:0]         ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-BUS_W-1:0]  a_hi,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     dt_r,
  output logic                     io_m,
  output logic                     sso
);
  localparam int WORD_W = 2 * BUS_W;

  bus_state_e        st_q;
  bus_state_e        st_d;
  logic              beat_q;
  logic              beat_d;
  logic              write_q;
  logic              write_d;
  logic              io_d;
  logic [ADDR_W-1:0] addr_d;
  logic [WORD_W-1:0] wdata_d;

  bus8_seq #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) seq_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_io(req_io), .req_halt(req_halt), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready),
    .st_q(st_q), .st_d(st_d), .beat_q(beat_q), .beat_d(beat_d),
    .write_q(write_q), .write_d(write_d), .io_d(io_d),
    .addr_d(addr_d), .wdata_d(wdata_d),
    .req_ready(req_ready), .done(done)
  );

  bus8_strobe strobe_i (
    .clk(clk), .rst(rst), .st_d(st_d), .write_d(write_d), .io_d(io_d),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .dt_r(dt_r), .sso(sso)
  );

  bus8_addr_path #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) addr_i (
    .clk(clk), .rst(rst), .st_d(st_d), .beat_d(beat_d), .write_d(write_d),
    .addr_d(addr_d), .wdata_d(wdata_d),
    .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  bus8_rdata_asm #(.BUS_W(BUS_W)) rdat_i (
    .clk(clk), .rst(rst), .st_q(st_q), .beat_q(beat_q), .write_q(write_q),
    .ready(ready), .ad_in(ad_in), .rdata(rdata)
  );

endmodule

// File: rtl/bus8_cycle_ctrl_chk.sv
module bus8_cycle_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     ale,
  input logic                     rd_n,
  input logic                     wr_n,
  input logic                     ad_oe,
  input logic [ADDR_W-BUS_W-1:0]  a_hi,
  input logic                     dt_r,
  input logic                     io_m,
  input logic                     sso,
  input logic                     done,
  input logic                     req_ready
);
  logic strobe;
  logic halt_code;
  assign strobe    = !rd_n || !wr_n;
  assign halt_code = io_m && dt_r && sso;

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst) !(!rd_n && !wr_n)); // R2
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (rst) ale |-> (rd_n && wr_n)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R2
  AST_AHI_HELD: assert property (@(posedge clk) disable iff (rst) strobe |-> $stable(a_hi)); // R5
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst) !rd_n |-> !ad_oe); // R6
  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (rst) !wr_n |-> ad_oe); // R6
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (rst) strobe |-> ($stable(dt_r) && $stable(io_m))); // R7
  AST_SSO_INVERSE: assert property (@(posedge clk) disable iff (rst) strobe |-> (sso != dt_r)); // R7
  AST_HALT_ALE_LATE: assert property (@(posedge clk) disable iff (rst) (ale && halt_code) |-> $past(halt_code && !ale)); // R9
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) ($fell(ale) && halt_code) |=> (!ale && !req_ready && halt_code)); // R9

endmodule

bind bus8_cycle_ctrl bus8_cycle_ctrl_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) chk_i (
  .clk(clk), .rst(rst), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe),
  .a_hi(a_hi), .dt_r(dt_r), .io_m(io_m), .sso(sso), .done(done),
  .req_ready(req_ready)
);

// File: tb/bus8_cycle_ctrl_tb_top.sv
module bus8_cycle_ctrl_tb_top;
  localparam int ADDR_W = 16;
  localparam int BUS_W  = 8;
  localparam int NVEC   = 8;

  // vector: {write, wide, io, waits[1:0], addr[15:0], wdata[15:0]}
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 16'h1234, 16'h0000},
    {1'b1, 1'b0, 1'b0, 2'd0, 16'h2000, 16'h00AB},
    {1'b0, 1'b1, 1'b1, 2'd1, 16'h0040, 16'h0000},
    {1'b1, 1'b1, 1'b0, 2'd2, 16'h3456, 16'hBEEF},
    {1'b0, 1'b1, 1'b0, 2'd0, 16'hFFFF, 16'h0000},
    {1'b1, 1'b0, 1'b1, 2'd3, 16'h00F0, 16'h0055},
    {1'b0, 1'b0, 1'b1, 2'd2, 16'h8001, 16'h0000},
    {1'b1, 1'b1, 1'b1, 2'd0, 16'h7FFF, 16'h1357}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst = 1'b1;
  logic              req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic              req_io = 1'b0, req_halt = 1'b0;
  logic [15:0]       req_addr = '0, req_wdata = '0;
  logic              req_ready, done;
  logic [15:0]       rdata;
  logic              ready = 1'b1;
  logic [7:0]        ad_in, ad_out;
  logic              ad_oe;
  logic [7:0]        a_hi;
  logic              ale, rd_n, wr_n, dt_r, io_m, sso;

  bus8_cycle_ctrl #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_io(req_io), .req_halt(req_halt),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .ready(ready), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .dt_r(dt_r), .io_m(io_m), .sso(sso)
  );

  // slave model: latch address during ale, answer with a fixed function of it
  function automatic logic [7:0] mem_byte(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  logic [15:0] lat_addr = '0;
  always @(negedge clk) if (ale) lat_addr <= {a_hi, ad_out};
  assign ad_in = mem_byte(lat_addr);

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input bit wr, input bit wide, input bit io, input int waits,
                          input logic [15:0] addr, input logic [15:0] wdata);
    int n, beats, k, strobes;
    logic [15:0] exp_a;
    logic [15:0] exp_rd;
    @(negedge clk);
    chk("R2 req_ready idle", 32'(req_ready), 32'd1);
    req_write = wr; req_wide = wide; req_io = io; req_halt = 1'b0;
    req_addr = addr; req_wdata = wdata; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1; beats = 0; k = 0; strobes = 0;
    while (!done && n < 64) begin
      if (ale) begin
        beats++;
        k = 0;
        exp_a = addr + 16'(beats - 1);
        chk("R4/R6 address on lines", 32'({a_hi, ad_out}), 32'(exp_a));
        chk("R6 ad_oe in T1", 32'(ad_oe), 32'd1);
        chk("R7 io_m", 32'(io_m), 32'(io));
        chk("R7 dt_r", 32'(dt_r), 32'(wr));
        chk("R7 sso", 32'(sso), 32'(!wr));
        chk("R2 req_ready busy", 32'(req_ready), 32'd0);
      end
      if (!rd_n || !wr_n) begin
        k++;
        strobes++;
        ready = (k >= 2 + waits);
        chk("R5 a_hi held", 32'(a_hi), 32'(exp_a[15:8]));
        chk("R2 strobe matches direction", 32'(wr ? rd_n : wr_n), 32'd1);
        if (k == 1) begin
          if (wr) begin
            chk("R6 write drives", 32'(ad_oe), 32'd1);
            chk("R6 write byte", 32'(ad_out), 32'(beats == 1 ? wdata[7:0] : wdata[15:8]));
          end else begin
            chk("R6 read releases", 32'(ad_oe), 32'd0);
          end
        end
      end
      @(negedge clk);
      n++;
    end
    ready = 1'b1;
    chk(waits > 0 ? "R3 done cycle with waits" : (wide ? "R4 done cycle wide" : "R2 done cycle"),
        32'(n), 32'((wide ? 9 : 5) + (wide ? 2 : 1) * waits));
    chk("R4 byte cycles", 32'(beats), 32'(wide ? 2 : 1));
    chk("R3 strobe cycles", 32'(strobes), 32'(beats * (2 + waits)));
    if (!wr) begin
      exp_rd = wide ? {mem_byte(addr + 16'd1), mem_byte(addr)} : {8'h00, mem_byte(addr)};
      chk("R8 rdata", 32'(rdata), 32'(exp_rd));
    end
  endtask

  task automatic chk_idle_outputs(input string req);
    chk(req, 32'({ale, rd_n, wr_n, ad_oe, done, req_ready}), 32'b011001);
    chk(req, 32'({io_m, dt_r, sso}), 32'b011);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk_idle_outputs("R1 reset outputs");
    rst = 1'b0;
    @(negedge clk);
    chk_idle_outputs("R1 after release");

    // table of transfers
    for (int i = 0; i < NVEC; i++) begin
      run_xfer(VEC[i][36], VEC[i][35], VEC[i][34], int'(VEC[i][33:32]),
               VEC[i][31:16], VEC[i][15:0]);
    end

    // R9 halt, with req_write also set: halt wins
    @(negedge clk);
    req_halt = 1'b1; req_write = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_halt = 1'b0;
    chk("R9 halt status before ale", 32'({ale, io_m, dt_r, sso, rd_n, wr_n}), 32'b011111);
    @(negedge clk);
    chk("R9 delayed ale", 32'({ale, io_m, dt_r, sso}), 32'b1111);
    @(negedge clk);
    chk("R9 halted", 32'({ale, req_ready}), 32'b00);
    req_write = 1'b0; req_addr = 16'h4444; req_valid = 1'b1;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk("R9 request ignored", 32'({ale, rd_n, wr_n, done, req_ready, ad_oe}), 32'b011000);
    end
    req_valid = 1'b0;

    // reset leaves halt
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk_idle_outputs("R1 reset from halt");
    rst = 1'b0;
    run_xfer(1'b0, 1'b0, 1'b0, 0, 16'h0A0B, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule